// File: doc/BRIEF.md
# IDE DMA chunk sequencer

This block sits between a descriptor-driven DMA engine and a storage back end during a bus-master IDE data phase. When a command is started it captures the command context, loads the number of bytes the command still owes, clears a running byte index, arms an internal active flag and sends a one-cycle kick to the DMA engine. The engine then offers memory chunks (address and length), one at a time. The sequencer takes one of six actions for each chunk:

- stall it;
- close the command;
- close the current segment;
- copy a small non-block optical reply;
- reject a bad disk command;
- turn the chunk into a storage request at a computed byte offset.

Storage requests use a request/acknowledge handshake. The next chunk is accepted only after the acknowledge. An error flag returned with the acknowledge aborts the transfer. Disk commands use 512-byte sectors, and optical packet transfers use 2048-byte blocks. All result pulses are registered and last one cycle.

Top module: `ide_dma_sequencer`

## Requirements
- R1: A one-cycle `start_i` pulse sets up the command, and the cycle after it `kick_o` pulses and `active_o` is 1. The byte index is cleared. The remaining count is `sector_cnt_i`×512 for a disk (`optical_i`=0) or `pkt_size_i` for an optical drive.
- R2: A chunk accepted while `active_o` is 0 makes the sequencer pulse `chunk_stall_o` the next cycle. No storage request, no end pulse and no completion follows.
- R3: When a chunk is accepted while the remaining count is zero or negative, the command finishes and `active_o` drops. A disk sets the level `status_ready_o` (cleared by the next start) and pulses `disk_irq_o`. An optical drive pulses `pkt_ok_o`. In both cases `chunk_end_o` pulses.
- R4: A zero-length chunk on an active command with bytes left pulses `chunk_end_o`. It issues no storage request and leaves the index, the remaining count and `active_o` unchanged.
- R5: For a disk, the request offset is `sector_i`×512 plus the byte index. `st_dir_o` copies the command code: 0 is read, 1 is write, 2 is trim.
- R6: For an optical drive, the request offset is `lba_i`×2048 plus the byte index, and `st_dir_o` is 0 (read).
- R7: Each issued request lowers the remaining count by the chunk length and raises the index by the same amount. The next request's offset and the finish decision follow from these new values.
- R8: An optical command with `lba_i` all ones is non-block. Its first active chunk pulses `copy_o` with `copy_addr_o` equal to the chunk address and `copy_len_o` equal to min(remaining, chunk length). It also pulses `pkt_ok_o` and `chunk_end_o`, clears `active_o` and issues no storage request.
- R9: A disk command with code 3 pulses `fatal_o` on its first active chunk that has bytes left, clears `active_o` and issues no request.
- R10: `st_req_o` and its offset, address, length and direction hold until `st_ack_i`. While it is held, `chunk_ready_o` is 0 and offered chunks are ignored. An acknowledge without an error drops the request and pulses `chunk_end_o` the next cycle.
- R11: An acknowledge with `st_err_i` pulses `dma_err_o` for a disk or `io_err_o` for an optical drive. It also pulses `chunk_end_o` and clears `active_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start pulse |
| optical_i | input | 1 | 1 for an optical packet drive, 0 for a disk |
| cmd_i | input | 2 | Disk command: 0 read, 1 write, 2 trim, 3 invalid |
| sector_cnt_i | input | SCNT_W | Disk sector count |
| pkt_size_i | input | XFER_W | Optical packet transfer size in bytes |
| sector_i | input | LBA_W | Disk starting sector |
| lba_i | input | LBA_W | Optical block address; all ones means non-block |
| kick_o | output | 1 | Pulse telling the DMA engine to run |
| active_o | output | 1 | Command armed |
| chunk_valid_i | input | 1 | Chunk offered |
| chunk_addr_i | input | ADDR_W | Chunk memory address |
| chunk_len_i | input | LEN_W | Chunk length in bytes |
| chunk_ready_o | output | 1 | Sequencer can take a chunk |
| chunk_stall_o | output | 1 | Pulse: chunk not processed |
| chunk_end_o | output | 1 | Pulse: end of DMA for the engine |
| st_req_o | output | 1 | Storage request |
| st_off_o | output | LBA_W+12 | Storage byte offset |
| st_addr_o | output | ADDR_W | Memory address of the request |
| st_len_o | output | LEN_W | Request length |
| st_dir_o | output | 2 | 0 read, 1 write, 2 trim |
| st_ack_i | input | 1 | Storage acknowledge |
| st_err_i | input | 1 | Error flag, valid with the acknowledge |
| copy_o | output | 1 | Pulse: non-block copy |
| copy_addr_o | output | ADDR_W | Copy destination |
| copy_len_o | output | LEN_W | Copy length |
| status_ready_o | output | 1 | Disk ready and seek-complete status |
| disk_irq_o | output | 1 | Pulse: disk interrupt |
| pkt_ok_o | output | 1 | Pulse: packet command success |
| dma_err_o | output | 1 | Pulse: disk DMA error |
| io_err_o | output | 1 | Pulse: optical I/O error |
| fatal_o | output | 1 | Pulse: invalid disk command |

## Verification
Every result is a register, so each is checked one clock after the edge that samples its cause. The kick and active flag appear one edge after the start. Stall, finish, copy, fatal and the raised request appear one edge after the chunk is accepted. The end pulse and the error pulses appear one edge after the acknowledge. The bench drives inputs on falling edges and samples on the falling edge that follows the causing rising edge, which is where a one-cycle pulse is certainly present. Request hold is checked across several unacknowledged cycles, with a chunk offered in the middle of the wait.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_TRIM  = 2'd2,
    CMD_BAD   = 2'd3
  } xfer_cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

  localparam int unsigned DISK_SHIFT = 9;
  localparam int unsigned OPT_SHIFT  = 11;
endpackage

// File: rtl/ide_seq_ctx.sv
module ide_seq_ctx
  import ide_seq_pkg::*;
#(
  parameter int unsigned SCNT_W = 8,
  parameter int unsigned XFER_W = 24,
  parameter int unsigned LBA_W  = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              optical_i,
  input  logic [1:0]        cmd_i,
  input  logic [SCNT_W-1:0] scnt_i,
  input  logic [XFER_W-1:0] psize_i,
  input  logic [LBA_W-1:0]  sector_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic              issue_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              clr_act_i,
  output logic              active_o,
  output logic              kick_o,
  output logic [XFER_W:0]   rem_o,
  output logic [XFER_W:0]   idx_o,
  output logic              opt_o,
  output logic [1:0]        cmd_o,
  output logic [LBA_W-1:0]  sector_o,
  output logic [LBA_W-1:0]  lba_o
);
  localparam int unsigned RW = XFER_W + 1;

  logic [RW-1:0] disk_bytes;
  assign disk_bytes = RW'({scnt_i, {DISK_SHIFT{1'b0}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      kick_o   <= 1'b0;
      rem_o    <= '0;
      idx_o    <= '0;
      opt_o    <= 1'b0;
      cmd_o    <= CMD_READ;
      sector_o <= '0;
      lba_o    <= '0;
    end else begin
      kick_o <= start_i;
      if (start_i) begin
        active_o <= 1'b1;
        idx_o    <= '0;
        rem_o    <= optical_i ? RW'(psize_i) : disk_bytes;
        opt_o    <= optical_i;
        cmd_o    <= cmd_i;
        sector_o <= sector_i;
        lba_o    <= lba_i;
      end else begin
        if (issue_i) begin
          rem_o <= rem_o - RW'(len_i);
          idx_o <= idx_o + RW'(len_i);
        end
        if (clr_act_i) active_o <= 1'b0;
      end
    end
  end

  // R1: start arms the command and kicks the engine
  p_arm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o && kick_o && (idx_o == '0));
endmodule

// File: rtl/ide_seq_offset.sv
module ide_seq_offset
  import ide_seq_pkg::*;
#(
  parameter int unsigned LBA_W  = 32,
  parameter int unsigned XFER_W = 24,
  parameter int unsigned OFF_W  = LBA_W + 12
) (
  input  logic              optical_i,
  input  logic [LBA_W-1:0]  sector_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [XFER_W:0]   idx_i,
  output logic [OFF_W-1:0]  off_o
);
  logic [OFF_W-1:0] base;

  always_comb begin
    if (optical_i) base = OFF_W'({lba_i, {OPT_SHIFT{1'b0}}});
    else           base = OFF_W'({sector_i, {DISK_SHIFT{1'b0}}});
    off_o = base + OFF_W'(idx_i);
  end
endmodule

// File: rtl/ide_seq_ctrl.sv
module ide_seq_ctrl
  import ide_seq_pkg::*;
#(
  parameter int unsigned XFER_W = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  input  logic              active_i,
  input  logic [XFER_W:0]   rem_i,
  input  logic              optical_i,
  input  logic              nonblock_i,
  input  logic [1:0]        cmd_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              st_ack_i,
  input  logic              st_err_i,
  output logic              chunk_ready_o,
  output logic              issue_o,
  output logic              clr_act_o,
  output logic              stall_o,
  output logic              end_o,
  output logic              st_req_o,
  output logic [OFF_W-1:0]  st_off_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [LEN_W-1:0]  st_len_o,
  output logic [1:0]        st_dir_o,
  output logic              copy_o,
  output logic [ADDR_W-1:0] copy_addr_o,
  output logic [LEN_W-1:0]  copy_len_o,
  output logic              status_rdy_o,
  output logic              disk_irq_o,
  output logic              pkt_ok_o,
  output logic              dma_err_o,
  output logic              io_err_o,
  output logic              fatal_o
);
  seq_state_e state_q;

  logic take, rem_le0, live, len_zero, bad_cmd;
  logic d_stall, d_fin, d_seg, d_nb, d_bad, ack_fire;
  logic [XFER_W-1:0] rem_mag;
  logic [LEN_W-1:0]  cpy_len;

  always_comb begin
    take      = chunk_valid_i && (state_q == ST_IDLE);
    rem_le0   = rem_i[XFER_W] || (rem_i == '0);
    len_zero  = (chunk_len_i == '0);
    bad_cmd   = !optical_i && (cmd_i == CMD_BAD);
    live      = take && active_i && !rem_le0;
    d_stall   = take && !active_i;
    d_fin     = take && active_i && rem_le0;
    d_seg     = live && len_zero;
    d_nb      = live && !len_zero && optical_i && nonblock_i;
    d_bad     = live && !len_zero && bad_cmd;
    issue_o   = live && !len_zero && !(optical_i && nonblock_i) && !bad_cmd;
    ack_fire  = (state_q == ST_WAIT) && st_ack_i;
    clr_act_o = d_fin || d_nb || d_bad || (ack_fire && st_err_i);
    chunk_ready_o = (state_q == ST_IDLE);
    rem_mag   = rem_i[XFER_W-1:0];
    cpy_len   = (rem_mag < XFER_W'(chunk_len_i)) ? rem_mag[LEN_W-1:0] : chunk_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      stall_o      <= 1'b0;
      end_o        <= 1'b0;
      st_req_o     <= 1'b0;
      st_off_o     <= '0;
      st_addr_o    <= '0;
      st_len_o     <= '0;
      st_dir_o     <= CMD_READ;
      copy_o       <= 1'b0;
      copy_addr_o  <= '0;
      copy_len_o   <= '0;
      status_rdy_o <= 1'b0;
      disk_irq_o   <= 1'b0;
      pkt_ok_o     <= 1'b0;
      dma_err_o    <= 1'b0;
      io_err_o     <= 1'b0;
      fatal_o      <= 1'b0;
    end else begin
      stall_o    <= d_stall;
      end_o      <= d_fin || d_seg || d_nb || ack_fire;
      pkt_ok_o   <= (d_fin || d_nb) && optical_i;
      disk_irq_o <= d_fin && !optical_i;
      dma_err_o  <= ack_fire && st_err_i && !optical_i;
      io_err_o   <= ack_fire && st_err_i && optical_i;
      fatal_o    <= d_bad;
      copy_o     <= d_nb;
      if (start_i)                    status_rdy_o <= 1'b0;
      else if (d_fin && !optical_i)   status_rdy_o <= 1'b1;
      if (d_nb) begin
        copy_addr_o <= chunk_addr_i;
        copy_len_o  <= cpy_len;
      end
      if (issue_o) begin
        state_q   <= ST_WAIT;
        st_req_o  <= 1'b1;
        st_off_o  <= off_i;
        st_addr_o <= chunk_addr_i;
        st_len_o  <= chunk_len_i;
        st_dir_o  <= optical_i ? CMD_READ : cmd_i;
      end else if (ack_fire) begin
        state_q  <= ST_IDLE;
        st_req_o <= 1'b0;
      end
    end
  end

  // R10: request fields hold until acknowledged
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_req_o && !st_ack_i |=> st_req_o && $stable(st_off_o) && $stable(st_len_o)
                              && $stable(st_addr_o) && $stable(st_dir_o));
  // R11: an error result always comes with the end pulse
  p_err_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_err_o || io_err_o) |-> end_o);
  // R2: a stalled chunk raises no request and no end
  p_stall_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !end_o && !st_req_o);
  // R3: at most one kind of chunk outcome per cycle
  p_one_outcome_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stall_o, fatal_o, copy_o, dma_err_o || io_err_o, disk_irq_o}));
endmodule

// File: rtl/ide_dma_sequencer.sv
module ide_dma_sequencer
  import ide_seq_pkg::*;
#(
  parameter int unsigned SCNT_W = 8,
  parameter int unsigned XFER_W = 24,
  parameter int unsigned LBA_W  = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned OFF_W = LBA_W + 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              optical_i,
  input  logic [1:0]        cmd_i,
  input  logic [SCNT_W-1:0] sector_cnt_i,
  input  logic [XFER_W-1:0] pkt_size_i,
  input  logic [LBA_W-1:0]  sector_i,
  input  logic [LBA_W-1:0]  lba_i,
  output logic              kick_o,
  output logic              active_o,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  output logic              chunk_ready_o,
  output logic              chunk_stall_o,
  output logic              chunk_end_o,
  output logic              st_req_o,
  output logic [OFF_W-1:0]  st_off_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [LEN_W-1:0]  st_len_o,
  output logic [1:0]        st_dir_o,
  input  logic              st_ack_i,
  input  logic              st_err_i,
  output logic              copy_o,
  output logic [ADDR_W-1:0] copy_addr_o,
  output logic [LEN_W-1:0]  copy_len_o,
  output logic              status_ready_o,
  output logic              disk_irq_o,
  output logic              pkt_ok_o,
  output logic              dma_err_o,
  output logic              io_err_o,
  output logic              fatal_o
);
  logic              issue, clr_act, opt_q;
  logic [XFER_W:0]   rem_q, idx_q;
  logic [1:0]        cmd_q;
  logic [LBA_W-1:0]  sector_q, lba_q;
  logic [OFF_W-1:0]  off;

  ide_seq_ctx #(.SCNT_W(SCNT_W), .XFER_W(XFER_W), .LBA_W(LBA_W), .LEN_W(LEN_W)) u_ctx (
    .clk_i, .rst_ni, .start_i, .optical_i, .cmd_i,
    .scnt_i(sector_cnt_i), .psize_i(pkt_size_i), .sector_i, .lba_i,
    .issue_i(issue), .len_i(chunk_len_i), .clr_act_i(clr_act),
    .active_o, .kick_o, .rem_o(rem_q), .idx_o(idx_q),
    .opt_o(opt_q), .cmd_o(cmd_q), .sector_o(sector_q), .lba_o(lba_q)
  );

  ide_seq_offset #(.LBA_W(LBA_W), .XFER_W(XFER_W), .OFF_W(OFF_W)) u_off (
    .optical_i(opt_q), .sector_i(sector_q), .lba_i(lba_q), .idx_i(idx_q), .off_o(off)
  );

  ide_seq_ctrl #(.XFER_W(XFER_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .chunk_valid_i, .chunk_addr_i, .chunk_len_i,
    .active_i(active_o), .rem_i(rem_q), .optical_i(opt_q),
    .nonblock_i(lba_q == '1), .cmd_i(cmd_q), .off_i(off),
    .st_ack_i, .st_err_i, .chunk_ready_o, .issue_o(issue), .clr_act_o(clr_act),
    .stall_o(chunk_stall_o), .end_o(chunk_end_o), .st_req_o, .st_off_o,
    .st_addr_o, .st_len_o, .st_dir_o, .copy_o, .copy_addr_o, .copy_len_o,
    .status_rdy_o(status_ready_o), .disk_irq_o, .pkt_ok_o, .dma_err_o,
    .io_err_o, .fatal_o
  );
endmodule

// File: tb/ide_dma_sequencer_tb.sv
`timescale 1ns/1ps
module ide_dma_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 0, optical = 0, chunk_valid = 0, ack = 0, err = 0;
  logic [1:0]  cmd = 0;
  logic [7:0]  scnt = 0;
  logic [23:0] psize = 0;
  logic [31:0] sector = 0, lba = 0, caddr = 0;
  logic [15:0] clen = 0;
  logic kick, active, ready, stall, cend, sreq, cpy, srdy, dirq, pok, derr, ierr, fatal;
  logic [43:0] soff;
  logic [31:0] saddr, cpy_addr;
  logic [15:0] slen, cpy_len;
  logic [1:0]  sdir;

  ide_dma_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .optical_i(optical), .cmd_i(cmd),
    .sector_cnt_i(scnt), .pkt_size_i(psize), .sector_i(sector), .lba_i(lba),
    .kick_o(kick), .active_o(active), .chunk_valid_i(chunk_valid),
    .chunk_addr_i(caddr), .chunk_len_i(clen), .chunk_ready_o(ready),
    .chunk_stall_o(stall), .chunk_end_o(cend), .st_req_o(sreq), .st_off_o(soff),
    .st_addr_o(saddr), .st_len_o(slen), .st_dir_o(sdir), .st_ack_i(ack),
    .st_err_i(err), .copy_o(cpy), .copy_addr_o(cpy_addr), .copy_len_o(cpy_len),
    .status_ready_o(srdy), .disk_irq_o(dirq), .pkt_ok_o(pok), .dma_err_o(derr),
    .io_err_o(ierr), .fatal_o(fatal)
  );

  int n_run = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic opt, input logic [1:0] c, input logic [31:0] base,
                           input logic [23:0] cnt);
    @(negedge clk);
    optical = opt; cmd = c; sector = base; lba = base;
    scnt = cnt[7:0]; psize = cnt; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    chk("R1 kick", 64'(kick), 64'd1);
    chk("R1 active", 64'(active), 64'd1);
  endtask

  task automatic send_chunk(input logic [31:0] a, input logic [15:0] l);
    caddr = a; clen = l; chunk_valid = 1;
    @(posedge clk);
    @(negedge clk);
    chunk_valid = 0;
  endtask

  task automatic give_ack(input logic e);
    ack = 1; err = e;
    @(posedge clk);
    @(negedge clk);
    ack = 0; err = 0;
  endtask

  typedef struct packed {
    logic        opt;
    logic [1:0]  cmd;
    logic [31:0] base;
    logic [23:0] cnt;
    logic [15:0] l1;
    logic [15:0] l2;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 2'd0, 32'd5,      24'd2,    16'd512,  16'd256},
    '{1'b0, 2'd1, 32'd100,    24'd1,    16'd512,  16'd64},
    '{1'b0, 2'd2, 32'd0,      24'd4,    16'd1000, 16'd8},
    '{1'b1, 2'd0, 32'd3,      24'd4096, 16'd2048, 16'd2048},
    '{1'b1, 2'd0, 32'd10,     24'd100,  16'd200,  16'd16},
    '{1'b0, 2'd0, 32'd65535,  24'd1,    16'd256,  16'd256}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset active", 64'(active), 64'd0);
    chk("R10 reset req", 64'(sreq), 64'd0);
    chk("R3 reset status", 64'(srdy), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset ready", 64'(ready), 64'd1);

    // R2: chunk before any command
    send_chunk(32'h100, 16'd512);
    chk("R2 stall", 64'(stall), 64'd1);
    chk("R2 no req", 64'(sreq), 64'd0);
    chk("R2 no end", 64'(cend), 64'd0);

    // table walk: R5 R6 R7 R3 R10
    foreach (VECS[i]) begin
      longint rem, boff;
      start_cmd(VECS[i].opt, VECS[i].cmd, VECS[i].base, VECS[i].cnt);
      rem  = VECS[i].opt ? longint'(VECS[i].cnt) : longint'(VECS[i].cnt) * 512;
      boff = VECS[i].opt ? longint'(VECS[i].base) * 2048 : longint'(VECS[i].base) * 512;
      send_chunk(32'h1000 + 32'(i), VECS[i].l1);
      chk("R5/R6 req", 64'(sreq), 64'd1);
      chk(VECS[i].opt ? "R6 offset" : "R5 offset", 64'(soff), 64'(boff));
      chk("R5 dir", 64'(sdir), VECS[i].opt ? 64'd0 : 64'(VECS[i].cmd));
      chk("R10 len", 64'(slen), 64'(VECS[i].l1));
      chk("R10 addr", 64'(saddr), 64'h1000 + 64'(i));
      chk("R10 ready low", 64'(ready), 64'd0);
      give_ack(1'b0);
      chk("R10 ack end", 64'(cend), 64'd1);
      chk("R10 ack drop", 64'(sreq), 64'd0);
      rem -= longint'(VECS[i].l1);
      send_chunk(32'h2000, VECS[i].l2);
      if (rem > 0) begin
        chk("R7 next offset", 64'(soff), 64'(boff + longint'(VECS[i].l1)));
        chk("R7 req", 64'(sreq), 64'd1);
        give_ack(1'b0);
      end else begin
        chk("R3 finish active", 64'(active), 64'd0);
        chk("R3 finish end", 64'(cend), 64'd1);
        chk("R7 no req", 64'(sreq), 64'd0);
        if (VECS[i].opt) chk("R3 pkt ok", 64'(pok), 64'd1);
        else begin
          chk("R3 disk irq", 64'(dirq), 64'd1);
          chk("R3 status", 64'(srdy), 64'd1);
        end
      end
    end

    // R2: after a finished command, chunk stalls until restarted
    start_cmd(1'b0, 2'd0, 32'd9, 24'd1);
    chk("R3 status cleared by start", 64'(srdy), 64'd0);
    send_chunk(32'h10, 16'd512);
    give_ack(1'b0);
    send_chunk(32'h20, 16'd512);
    chk("R3 disk done", 64'(dirq), 64'd1);
    send_chunk(32'h30, 16'd512);
    chk("R2 stall after done", 64'(stall), 64'd1);
    chk("R2 no req after done", 64'(sreq), 64'd0);

    // R4: zero-length chunk
    start_cmd(1'b0, 2'd0, 32'd2, 24'd2);
    send_chunk(32'h40, 16'd0);
    chk("R4 end", 64'(cend), 64'd1);
    chk("R4 no req", 64'(sreq), 64'd0);
    chk("R4 active kept", 64'(active), 64'd1);
    send_chunk(32'h50, 16'd512);
    chk("R4 index unchanged", 64'(soff), 64'd1024);
    // R10: hold with no ack and a chunk offered meanwhile
    repeat (2) @(negedge clk);
    send_chunk(32'h60, 16'd4);
    chk("R10 ignored chunk stall", 64'(stall), 64'd0);
    chk("R10 held req", 64'(sreq), 64'd1);
    chk("R10 held offset", 64'(soff), 64'd1024);
    chk("R10 held len", 64'(slen), 64'd512);
    give_ack(1'b0);
    // remaining 512 after ignored chunk; next chunk issues at index 512
    send_chunk(32'h70, 16'd512);
    chk("R10 ignored chunk kept index", 64'(soff), 64'd1536);
    give_ack(1'b0);

    // R8: non-block optical copy, remaining smaller than chunk
    start_cmd(1'b1, 2'd0, 32'hFFFF_FFFF, 24'd300);
    send_chunk(32'h2000, 16'd512);
    chk("R8 copy", 64'(cpy), 64'd1);
    chk("R8 copy len", 64'(cpy_len), 64'd300);
    chk("R8 copy addr", 64'(cpy_addr), 64'h2000);
    chk("R8 pkt ok", 64'(pok), 64'd1);
    chk("R8 end", 64'(cend), 64'd1);
    chk("R8 no req", 64'(sreq), 64'd0);
    chk("R8 inactive", 64'(active), 64'd0);
    // R8: chunk smaller than remaining
    start_cmd(1'b1, 2'd0, 32'hFFFF_FFFF, 24'd300);
    send_chunk(32'h3000, 16'd100);
    chk("R8 copy len short", 64'(cpy_len), 64'd100);

    // R9: invalid disk command
    start_cmd(1'b0, 2'd3, 32'd1, 24'd1);
    send_chunk(32'h80, 16'd512);
    chk("R9 fatal", 64'(fatal), 64'd1);
    chk("R9 no req", 64'(sreq), 64'd0);
    chk("R9 inactive", 64'(active), 64'd0);

    // R11: disk error
    start_cmd(1'b0, 2'd0, 32'd4, 24'd2);
    send_chunk(32'h90, 16'd512);
    give_ack(1'b1);
    chk("R11 dma err", 64'(derr), 64'd1);
    chk("R11 no io err", 64'(ierr), 64'd0);
    chk("R11 end", 64'(cend), 64'd1);
    chk("R11 inactive", 64'(active), 64'd0);
    // R11: optical error
    start_cmd(1'b1, 2'd0, 32'd1, 24'd4096);
    send_chunk(32'hA0, 16'd2048);
    give_ack(1'b1);
    chk("R11 io err", 64'(ierr), 64'd1);
    chk("R11 no dma err", 64'(derr), 64'd0);
    chk("R11 opt inactive", 64'(active), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule